// File: doc/BRIEF.md
# Machine Check Interrupt Entry Unit

This unit performs the register side of entering a machine-check interrupt on a 32-bit core whose registers are numbered 32 to 63, as in a 64-bit numbering. The core raises a one-cycle accept strobe when it takes a machine check. In the next cycle the unit does two things:

- It presents a handler fetch address, with a one-cycle valid pulse.
- It updates every captured register: two save/restore registers, an error address register with a validity flag, and a sticky syndrome register.

The handler address is formed from two fields. The first is the upper half of the vector prefix register. The second is the middle field of the machine-check offset register. Four zero bits follow them. Save register 0 holds the effective address of the instruction in flight. Save register 1 keeps a fixed, sparse subset of the machine state register. The error address register records the data address of the fault, except when an external signal raised the error. In that case the old content is kept and marked invalid.

Syndrome bits accumulate across errors. Each bit is cleared only when a one is written to its position through a clear strobe with a mask. Pipeline flush, the return sequence and arbitration between nested interrupts are left to other blocks.

Top module: `mce_entry`

## Requirements
- R1: While `rst` is high at a clock edge, every output goes to zero after that edge, `err_addr_ok` included.
- R2: `redirect_vld` is high in exactly the cycle after each cycle in which `mc_accept` is high, and is low in every other cycle.
- R3: After an accept, `redirect_pc` equals {`vec_prefix_hi`[15:0], `vec_offset_mid`[11:0], 4'b0000}. The prefix takes bits 31..16, the offset bits 15..4, and bits 3..0 are zero. The operands are those sampled in the accept cycle.
- R4: After an accept, `save0` equals the `inst_ea` sampled in the accept cycle.
- R5: After an accept, `save1` equals `msr_cur` ANDed with a keep mask. In big-endian numbering 32..63 the kept bits are 37–38, 46–55, 57–59 and 61–63, and big-endian bit n is vector index 63−n. This gives kept indices 26, 25, 17..8, 6..4 and 2..0, or 32'h0603_FF77. Every other bit of `save1` reads zero.
- R6: After an accept with `by_signal` low, `err_addr` equals the sampled `data_ea` and `err_addr_ok` is 1.
- R7: After an accept with `by_signal` high, `err_addr` keeps its previous value and `err_addr_ok` is 0.
- R8: After an accept, `syndrome` is its old value ORed with `cause`. Without a clear, no syndrome bit ever goes from 1 to 0.
- R9: When `syn_clr_vld` is high, syndrome bits that have a 1 in `syn_clr_mask` are cleared after that edge. A bit that is being set by a simultaneous accept ends at 1.
- R10: In a cycle without an accept, `redirect_pc`, `save0`, `save1`, `err_addr` and `err_addr_ok` hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_accept | input | 1 | One-cycle strobe: a machine check is taken |
| inst_ea | input | 32 | Effective address of the instruction executing or about to execute |
| msr_cur | input | 32 | Current machine state register |
| vec_prefix_hi | input | 16 | Vector prefix register, big-endian bits 32–47 |
| vec_offset_mid | input | 12 | Machine-check offset register, big-endian bits 48–59 |
| data_ea | input | 32 | Address of the data associated with the error |
| by_signal | input | 1 | The error was raised by an external signal |
| cause | input | CAUSE_W | Condition bits merged into the syndrome |
| syn_clr_vld | input | 1 | Write-one-to-clear strobe for the syndrome |
| syn_clr_mask | input | CAUSE_W | Syndrome bits to clear |
| redirect_vld | output | 1 | One-cycle valid for the handler address |
| redirect_pc | output | 32 | Handler fetch address |
| save0 | output | 32 | Save/restore register 0 |
| save1 | output | 32 | Save/restore register 1 |
| err_addr | output | 32 | Error address register |
| err_addr_ok | output | 1 | The error address content is meaningful |
| syndrome | output | CAUSE_W | Sticky syndrome register |

## Verification
Some properties are checked on every cycle, right next to the registers:

- the timing of the redirect pulse;
- the composition of the vector from the sampled fields;
- the masked copy of the state register;
- holding the error address and dropping its validity on signal-caused errors;
- syndrome stickiness, and the rule that a simultaneous set beats a clear.

Other behaviours only show up in the bench's scenarios, where a behavioural reference model is compared on every clock. These are the reset values and back-to-back accepts. They also include alternating data and signal causes, where an earlier valid address must survive a later signal error. Partial clears of an accumulated syndrome, and the hold of all captured registers while their inputs change without an accept, are covered there too.

// File: rtl/mce_pkg.sv
package mce_pkg;

  // Architectural register width; big-endian numbering runs 32..63.
  localparam int XLEN      = 32;
  localparam int NUM_BASE  = 64 - XLEN;
  localparam int PFX_W     = 16;
  localparam int OFF_W     = 12;
  localparam int ALIGN_W   = XLEN - PFX_W - OFF_W;

  // Big-endian bit number n maps to vector index 63-n.
  function automatic logic [XLEN-1:0] keep_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int idx = 0; idx < XLEN; idx++) begin
      int n;
      n = 63 - idx;
      if ((n >= 37 && n <= 38) || (n >= 46 && n <= 55) ||
          (n >= 57 && n <= 59) || (n >= 61 && n <= 63))
        m[idx] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [XLEN-1:0] SAVE1_KEEP = keep_mask();

endpackage

// File: rtl/mce_vector_gen.sv
module mce_vector_gen
  import mce_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mc_accept,
  input  logic [PFX_W-1:0] vec_prefix_hi,
  input  logic [OFF_W-1:0] vec_offset_mid,
  output logic             redirect_vld,
  output logic [XLEN-1:0]  redirect_pc
);

  logic [XLEN-1:0] pc_next;

  always_comb begin
    pc_next = {vec_prefix_hi, vec_offset_mid, {ALIGN_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_vld <= 1'b0;
      redirect_pc  <= '0;
    end else begin
      redirect_vld <= mc_accept;
      if (mc_accept) redirect_pc <= pc_next;
    end
  end

  // R2: pulse follows every accept
  a_r2_pulse_after_accept: assert property (@(posedge clk) disable iff (rst)
    mc_accept |=> redirect_vld);
  // R2: no pulse without a preceding accept
  a_r2_no_spurious_pulse: assert property (@(posedge clk) disable iff (rst)
    !mc_accept |=> !redirect_vld);
  // R3: vector built from the sampled fields
  a_r3_vector_fields: assert property (@(posedge clk) disable iff (rst)
    mc_accept |=> (redirect_pc[XLEN-1 -: PFX_W] == $past(vec_prefix_hi)) &&
                  (redirect_pc[ALIGN_W +: OFF_W] == $past(vec_offset_mid)) &&
                  (redirect_pc[ALIGN_W-1:0] == '0));
  // R10: vector holds without accept
  a_r10_vector_hold: assert property (@(posedge clk) disable iff (rst)
    !mc_accept |=> $stable(redirect_pc));

endmodule

// File: rtl/mce_state_save.sv
module mce_state_save
  import mce_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            mc_accept,
  input  logic [XLEN-1:0] inst_ea,
  input  logic [XLEN-1:0] msr_cur,
  output logic [XLEN-1:0] save0,
  output logic [XLEN-1:0] save1
);

  logic [XLEN-1:0] msr_kept;

  // One AND gate per kept bit; dropped bits are tied to zero.
  for (genvar g = 0; g < XLEN; g++) begin : g_keep
    if (SAVE1_KEEP[g]) begin : g_on
      assign msr_kept[g] = msr_cur[g];
    end else begin : g_off
      assign msr_kept[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      save0 <= '0;
      save1 <= '0;
    end else if (mc_accept) begin
      save0 <= inst_ea;
      save1 <= msr_kept;
    end
  end

  // R4: instruction address captured
  a_r4_save0_capture: assert property (@(posedge clk) disable iff (rst)
    mc_accept |=> save0 == $past(inst_ea));
  // R5: reserved positions of save1 read zero
  a_r5_save1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    mc_accept |=> (save1 & ~SAVE1_KEEP) == '0);
  // R5: kept positions copy the state register
  a_r5_save1_kept_bits: assert property (@(posedge clk) disable iff (rst)
    mc_accept |=> (save1 & SAVE1_KEEP) == ($past(msr_cur) & SAVE1_KEEP));
  // R10: save registers hold without accept
  a_r10_save_hold: assert property (@(posedge clk) disable iff (rst)
    !mc_accept |=> $stable(save0) && $stable(save1));

endmodule

// File: rtl/mce_err_log.sv
module mce_err_log
  import mce_pkg::*;
#(
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mc_accept,
  input  logic [XLEN-1:0]    data_ea,
  input  logic               by_signal,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               syn_clr_vld,
  input  logic [CAUSE_W-1:0] syn_clr_mask,
  output logic [XLEN-1:0]    err_addr,
  output logic               err_addr_ok,
  output logic [CAUSE_W-1:0] syndrome
);

  logic [CAUSE_W-1:0] clr_bits;
  logic [CAUSE_W-1:0] set_bits;
  logic [CAUSE_W-1:0] syn_next;

  always_comb begin
    clr_bits = syn_clr_vld ? syn_clr_mask : '0;
    set_bits = mc_accept   ? cause        : '0;
    syn_next = (syndrome & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_addr    <= '0;
      err_addr_ok <= 1'b0;
      syndrome    <= '0;
    end else begin
      syndrome <= syn_next;
      if (mc_accept) begin
        err_addr_ok <= !by_signal;
        if (!by_signal) err_addr <= data_ea;
      end
    end
  end

  // R6: data-caused error records its address
  a_r6_addr_capture: assert property (@(posedge clk) disable iff (rst)
    (mc_accept && !by_signal) |=> (err_addr == $past(data_ea)) && err_addr_ok);
  // R7: signal-caused error keeps address, marks invalid
  a_r7_signal_keeps_addr: assert property (@(posedge clk) disable iff (rst)
    (mc_accept && by_signal) |=> $stable(err_addr) && !err_addr_ok);
  // R8: without a clear no bit falls
  a_r8_syndrome_sticky: assert property (@(posedge clk) disable iff (rst)
    !syn_clr_vld |=> (syndrome & $past(syndrome)) == $past(syndrome));
  // R9: a simultaneous set wins over a clear
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    mc_accept |=> (syndrome & $past(cause)) == $past(cause));
  // R10: error address holds without accept
  a_r10_err_hold: assert property (@(posedge clk) disable iff (rst)
    !mc_accept |=> $stable(err_addr) && $stable(err_addr_ok));

endmodule

// File: rtl/mce_entry.sv
module mce_entry
  import mce_pkg::*;
#(
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mc_accept,
  input  logic [XLEN-1:0]    inst_ea,
  input  logic [XLEN-1:0]    msr_cur,
  input  logic [PFX_W-1:0]   vec_prefix_hi,
  input  logic [OFF_W-1:0]   vec_offset_mid,
  input  logic [XLEN-1:0]    data_ea,
  input  logic               by_signal,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               syn_clr_vld,
  input  logic [CAUSE_W-1:0] syn_clr_mask,
  output logic               redirect_vld,
  output logic [XLEN-1:0]    redirect_pc,
  output logic [XLEN-1:0]    save0,
  output logic [XLEN-1:0]    save1,
  output logic [XLEN-1:0]    err_addr,
  output logic               err_addr_ok,
  output logic [CAUSE_W-1:0] syndrome
);

  mce_vector_gen u_vector (
    .clk            (clk),
    .rst            (rst),
    .mc_accept      (mc_accept),
    .vec_prefix_hi  (vec_prefix_hi),
    .vec_offset_mid (vec_offset_mid),
    .redirect_vld   (redirect_vld),
    .redirect_pc    (redirect_pc)
  );

  mce_state_save u_save (
    .clk       (clk),
    .rst       (rst),
    .mc_accept (mc_accept),
    .inst_ea   (inst_ea),
    .msr_cur   (msr_cur),
    .save0     (save0),
    .save1     (save1)
  );

  mce_err_log #(.CAUSE_W(CAUSE_W)) u_err (
    .clk          (clk),
    .rst          (rst),
    .mc_accept    (mc_accept),
    .data_ea      (data_ea),
    .by_signal    (by_signal),
    .cause        (cause),
    .syn_clr_vld  (syn_clr_vld),
    .syn_clr_mask (syn_clr_mask),
    .err_addr     (err_addr),
    .err_addr_ok  (err_addr_ok),
    .syndrome     (syndrome)
  );

  // R2: the pulse and the captured registers move together
  a_r2_capture_with_pulse: assert property (@(posedge clk) disable iff (rst)
    !redirect_vld |-> $stable(save0) || $past(rst));

endmodule

// File: tb/mce_entry_bench.sv
module mce_entry_bench;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          mc_accept;
  logic [31:0]   inst_ea, msr_cur, data_ea;
  logic [15:0]   vec_prefix_hi;
  logic [11:0]   vec_offset_mid;
  logic          by_signal;
  logic [CW-1:0] cause, syn_clr_mask;
  logic          syn_clr_vld;
  logic          redirect_vld, err_addr_ok;
  logic [31:0]   redirect_pc, save0, save1, err_addr;
  logic [CW-1:0] syndrome;

  mce_entry #(.CAUSE_W(CW)) u_mce_entry (
    .clk(clk), .rst(rst), .mc_accept(mc_accept), .inst_ea(inst_ea),
    .msr_cur(msr_cur), .vec_prefix_hi(vec_prefix_hi),
    .vec_offset_mid(vec_offset_mid), .data_ea(data_ea),
    .by_signal(by_signal), .cause(cause), .syn_clr_vld(syn_clr_vld),
    .syn_clr_mask(syn_clr_mask), .redirect_vld(redirect_vld),
    .redirect_pc(redirect_pc), .save0(save0), .save1(save1),
    .err_addr(err_addr), .err_addr_ok(err_addr_ok), .syndrome(syndrome)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state
  logic          m_vld, m_ok;
  logic [31:0]   m_pc, m_s0, m_s1, m_ea;
  logic [CW-1:0] m_syn;
  logic [31:0]   keep;
  bit            in_reset;

  // Keep mask from the stated big-endian bit list
  initial begin
    int kept_nums[18] = '{37,38,46,47,48,49,50,51,52,53,54,55,57,58,59,61,62,63};
    keep = '0;
    foreach (kept_nums[k]) keep[63 - kept_nums[k]] = 1'b1;
  end

  always @(posedge clk) begin
    in_reset = rst;
    if (rst) begin
      m_vld = 0; m_ok = 0; m_pc = 0; m_s0 = 0; m_s1 = 0; m_ea = 0; m_syn = 0;
    end else begin
      m_vld = mc_accept;
      if (syn_clr_vld) m_syn = m_syn & ~syn_clr_mask;
      if (mc_accept) begin
        m_pc  = {vec_prefix_hi, vec_offset_mid, 4'b0000};
        m_s0  = inst_ea;
        m_s1  = msr_cur & keep;
        m_syn = m_syn | cause;
        if (by_signal) m_ok = 0;
        else begin
          m_ok = 1;
          m_ea = data_ea;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // Compare on every falling edge, after all registers settled
  always @(negedge clk) begin
    if (!done && $time > 15) begin
      if (in_reset) begin
        chk("R1 redirect_vld", {31'b0, redirect_vld}, 32'h0);
        chk("R1 redirect_pc", redirect_pc, 32'h0);
        chk("R1 save0", save0, 32'h0);
        chk("R1 save1", save1, 32'h0);
        chk("R1 err_addr", err_addr, 32'h0);
        chk("R1 err_addr_ok", {31'b0, err_addr_ok}, 32'h0);
        chk("R1 syndrome", {24'b0, syndrome}, 32'h0);
      end else begin
        chk("R2 redirect_vld", {31'b0, redirect_vld}, {31'b0, m_vld});
        chk("R3/R10 redirect_pc", redirect_pc, m_pc);
        chk("R4/R10 save0", save0, m_s0);
        chk("R5/R10 save1", save1, m_s1);
        chk("R6/R7 err_addr", err_addr, m_ea);
        chk("R6/R7 err_addr_ok", {31'b0, err_addr_ok}, {31'b0, m_ok});
        chk("R8/R9 syndrome", {24'b0, syndrome}, {24'b0, m_syn});
      end
    end
  end

  task automatic idle_inputs();
    mc_accept = 0; syn_clr_vld = 0; syn_clr_mask = 0; cause = 0; by_signal = 0;
  endtask

  task automatic scramble();
    inst_ea = $urandom; msr_cur = $urandom; data_ea = $urandom;
    vec_prefix_hi = 16'($urandom); vec_offset_mid = 12'($urandom);
  endtask

  task automatic accept(input logic sig, input logic [CW-1:0] c);
    @(negedge clk);
    scramble();
    mc_accept = 1; by_signal = sig; cause = c;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic clear(input logic [CW-1:0] m);
    @(negedge clk);
    syn_clr_vld = 1; syn_clr_mask = m;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rst = 1; idle_inputs(); scramble();
    repeat (3) @(negedge clk);
    // R1: reset state checked while rst high; toggle inputs meanwhile
    mc_accept = 1; cause = 8'hFF;
    @(negedge clk);
    idle_inputs();
    rst = 0;
    repeat (2) @(negedge clk);
    // R3, R4, R5, R6: data-caused entry with all-ones state
    @(negedge clk); msr_cur = 32'hFFFF_FFFF; inst_ea = 32'h1000_0040;
    vec_prefix_hi = 16'hFFFF; vec_offset_mid = 12'hFFF; data_ea = 32'hDEAD_BEE0;
    mc_accept = 1; cause = 8'h01;
    @(negedge clk); idle_inputs();
    // R7: signal-caused entry keeps previous address
    accept(1'b1, 8'h04);
    // R10: inputs change without accept
    repeat (4) begin @(negedge clk); scramble(); end
    // R2: back-to-back accepts
    @(negedge clk); scramble(); mc_accept = 1; cause = 8'h10;
    @(negedge clk); scramble(); by_signal = 1; cause = 8'h20;
    @(negedge clk); idle_inputs();
    // R9: partial clear, then clear colliding with set
    clear(8'h05);
    @(negedge clk); scramble(); mc_accept = 1; cause = 8'h10;
    syn_clr_vld = 1; syn_clr_mask = 8'hFF;
    @(negedge clk); idle_inputs();
    // R8: mixed sequence
    for (int i = 0; i < 60; i++) begin
      if (i % 3 == 0) accept(1'(i % 2), 8'($urandom));
      else if (i % 7 == 0) clear(8'($urandom));
      else begin @(negedge clk); scramble(); end
    end
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

endmodule